// File: doc/BRIEF.md
# GPIO Controller with Edge and Level Interrupts

This block is an eight-line general-purpose I/O controller on a simple byte-wide register bus. Each line can be an input or an output. Output lines are driven from a data register. Input lines are sampled from the pads through a two-flop synchroniser. Accesses to the data register carry a bit mask in the address, so software can update or read any subset of lines in a single access, with no read-modify-write.

Each line also has an interrupt detector. It can be set to sense a level (high or low), a single edge (rising or falling) or both edges. A latched edge event stays set until software clears it by writing a one to its bit. A level condition is never latched and follows the pad. Enable bits gate the raw status into a masked status, and one combined interrupt output is the OR of all masked bits.

Reads are combinational from the current address. Writes take effect on the clock edge where `we_i` is high.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every register reads 0: all lines are inputs, the data register is 0, all lines are in single-edge mode sensing falling edges, and all enables and latched events are 0. `pad_oe_o` and `irq_o` are 0.
- R2: A write to a byte address below 0x400 updates data bit n only where address bit n+2 is 1; the other bits hold. `pad_o` shows the data register.
- R3: Direction register at 0x400: bit n = 1 makes line n an output, 0 an input. `pad_oe_o` shows this register.
- R4: A read below 0x400 returns, for each bit whose address mask bit n+2 is 1, the data register bit if line n is an output, or the synchronised pad bit if line n is an input. All other bits read 0. A pad change first becomes visible two rising clock edges after it is sampled.
- R5: Sense register at 0x404: bit n = 1 puts line n in level mode. In that mode the raw status bit equals the synchronised pad when event bit n (0x40C) is 1, and its inverse when it is 0. It is never latched, and writes to the clear register do not affect it.
- R6: When sense bit n and both-edges bit n (0x408) are 0, a rising edge of the synchronised input latches raw bit n if event bit n is 1. A falling edge latches it if event bit n is 0.
- R7: When both-edges bit n is 1 in edge mode, either edge latches raw bit n, whatever the event bit holds.
- R8: Enable register at 0x410. The masked status at 0x418 is the raw status (0x414) ANDed with the enable register. `irq_o` is 1 exactly when some masked bit is 1.
- R9: A write to 0x41C clears each latched edge event whose data bit is 1. Bits written as 0 keep their state.
- R10: If an edge event and a clear of the same line fall on the same clock edge, the event wins and the bit stays set.
- R11: Writes to 0x414 and 0x418 have no effect. The clear register and any unmapped address at or above 0x400 read 0, and writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 11 | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| pad_i | input | 8 | Pad input levels |
| pad_o | output | 8 | Output values to pads |
| pad_oe_o | output | 8 | Per-line output enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check that:
- a latched edge bit rises only with a detected event;
- a clear drops a bit unless an event arrives on the same edge;
- the interrupt output never rises with all enables off;
- pad values and output enables change only on writes;
- a masked data write leaves unselected lines alone.

Other behaviour needs the bench's scenarios and its per-cycle reference model. This covers the two-cycle synchroniser latency, level tracking in both polarities, the event bit being ignored in both-edge mode, the event winning over a clear on the same edge, and the read-only and unmapped addresses.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    SEL_DIR   = 3'd0,
    SEL_SENSE = 3'd1,
    SEL_BOTH  = 3'd2,
    SEL_EVENT = 3'd3,
    SEL_IE    = 3'd4,
    SEL_RAW   = 3'd5,
    SEL_MIS   = 3'd6,
    SEL_CLR   = 3'd7
  } ctl_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  // one extra stage past the synchroniser keeps the previous value for edge detection
  logic [STAGES:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s <= STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
  assign prev_o = stage_q[STAGES];
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic prev_i,
  input  logic sense_i,
  input  logic both_i,
  input  logic event_i,
  input  logic clr_i,
  output logic raw_o,
  output logic edge_o,
  output logic hit_o
);
  logic rise, fall, level_act, edge_q;

  assign rise      = sync_i & ~prev_i;
  assign fall      = ~sync_i & prev_i;
  assign hit_o     = ~sense_i & (both_i ? (rise | fall) : (event_i ? rise : fall));
  assign level_act = event_i ? sync_i : ~sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     edge_q <= 1'b0;
    else if (hit_o)  edge_q <= 1'b1;  // new event beats a same-cycle clear
    else if (clr_i)  edge_q <= 1'b0;
  end

  assign edge_o = edge_q;
  assign raw_o  = sense_i ? level_act : edge_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int unsigned NLINES = 8,
  parameter int unsigned AW     = NLINES + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [NLINES-1:0] wdata_i,
  input  logic [NLINES-1:0] sync_i,
  input  logic [NLINES-1:0] raw_i,
  output logic [NLINES-1:0] data_o,
  output logic [NLINES-1:0] dir_o,
  output logic [NLINES-1:0] sense_o,
  output logic [NLINES-1:0] both_o,
  output logic [NLINES-1:0] event_o,
  output logic [NLINES-1:0] ie_o,
  output logic [NLINES-1:0] clr_o,
  output logic [NLINES-1:0] mis_o,
  output logic [NLINES-1:0] rdata_o
);
  // data window below REGION_BIT, control block above; needs NLINES >= 4
  localparam int unsigned REGION_BIT = NLINES + 2;

  logic              data_sel, ctl_hit;
  logic [NLINES-1:0] mask;
  ctl_sel_e          sel;
  logic [NLINES-1:0] data_q, dir_q, sense_q, both_q, event_q, ie_q;
  logic              unused_addr;

  assign data_sel    = ~addr_i[REGION_BIT];
  assign mask        = addr_i[NLINES+1:2];
  assign ctl_hit     = addr_i[REGION_BIT] && (addr_i[REGION_BIT-1:5] == '0);
  assign sel         = ctl_sel_e'(addr_i[4:2]);
  assign unused_addr = ^addr_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      event_q <= '0;
      ie_q    <= '0;
    end else if (we_i) begin
      if (data_sel) begin
        data_q <= (data_q & ~mask) | (wdata_i & mask);
      end else if (ctl_hit) begin
        case (sel)
          SEL_DIR:   dir_q   <= wdata_i;
          SEL_SENSE: sense_q <= wdata_i;
          SEL_BOTH:  both_q  <= wdata_i;
          SEL_EVENT: event_q <= wdata_i;
          SEL_IE:    ie_q    <= wdata_i;
          default:   ;
        endcase
      end
    end
  end

  assign clr_o = (we_i && ctl_hit && sel == SEL_CLR) ? wdata_i : '0;
  assign mis_o = raw_i & ie_q;

  always_comb begin
    rdata_o = '0;
    if (data_sel) begin
      rdata_o = ((dir_q & data_q) | (~dir_q & sync_i)) & mask;
    end else if (ctl_hit) begin
      case (sel)
        SEL_DIR:   rdata_o = dir_q;
        SEL_SENSE: rdata_o = sense_q;
        SEL_BOTH:  rdata_o = both_q;
        SEL_EVENT: rdata_o = event_q;
        SEL_IE:    rdata_o = ie_q;
        SEL_RAW:   rdata_o = raw_i;
        SEL_MIS:   rdata_o = mis_o;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign data_o  = data_q;
  assign dir_o   = dir_q;
  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign event_o = event_q;
  assign ie_o    = ie_q;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl #(
  parameter int unsigned NLINES      = 8,
  parameter int unsigned AW          = NLINES + 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [NLINES-1:0] wdata_i,
  output logic [NLINES-1:0] rdata_o,
  input  logic [NLINES-1:0] pad_i,
  output logic [NLINES-1:0] pad_o,
  output logic [NLINES-1:0] pad_oe_o,
  output logic              irq_o
);
  logic [NLINES-1:0] sync_w, prev_w, data_w, dir_w, sense_w, both_w, event_w;
  logic [NLINES-1:0] ie_w, clr_w, raw_w, edge_w, hit_w, mis_w;

  gpio_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_i),
    .sync_o  (sync_w),
    .prev_o  (prev_w)
  );

  for (genvar n = 0; n < NLINES; n++) begin : g_line
    gpio_irq_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sync_i  (sync_w[n]),
      .prev_i  (prev_w[n]),
      .sense_i (sense_w[n]),
      .both_i  (both_w[n]),
      .event_i (event_w[n]),
      .clr_i   (clr_w[n]),
      .raw_o   (raw_w[n]),
      .edge_o  (edge_w[n]),
      .hit_o   (hit_w[n])
    );
  end

  gpio_regfile #(.NLINES(NLINES), .AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .sync_i  (sync_w),
    .raw_i   (raw_w),
    .data_o  (data_w),
    .dir_o   (dir_w),
    .sense_o (sense_w),
    .both_o  (both_w),
    .event_o (event_w),
    .ie_o    (ie_w),
    .clr_o   (clr_w),
    .mis_o   (mis_w),
    .rdata_o (rdata_o)
  );

  assign pad_o    = data_w;
  assign pad_oe_o = dir_w;
  assign irq_o    = |mis_w;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int unsigned NLINES = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic              dsel_i,
  input logic [NLINES-1:0] mask_i,
  input logic [NLINES-1:0] pad_o,
  input logic [NLINES-1:0] pad_oe_o,
  input logic              irq_o,
  input logic [NLINES-1:0] edge_i,
  input logic [NLINES-1:0] hit_i,
  input logic [NLINES-1:0] clr_i,
  input logic [NLINES-1:0] ie_i
);
  assert_edge_only_on_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((edge_i & ~$past(edge_i) & ~$past(hit_i)) == '0));

  assert_hit_latches_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0) |=> ((edge_i & $past(hit_i)) == $past(hit_i)));

  assert_clear_drops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((edge_i & $past(clr_i) & ~$past(hit_i)) == '0));

  assert_irq_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ie_i != '0));

  assert_pad_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(pad_o));

  assert_pad_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && dsel_i) |=> (((pad_o ^ $past(pad_o)) & ~$past(mask_i)) == '0));

  assert_dir_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(pad_oe_o));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NLINES(NLINES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .dsel_i   (!addr_i[NLINES+2]),
  .mask_i   (addr_i[NLINES+1:2]),
  .pad_o    (pad_o),
  .pad_oe_o (pad_oe_o),
  .irq_o    (irq_o),
  .edge_i   (edge_w),
  .hit_i    (hit_w),
  .clr_i    (clr_w),
  .ie_i     (ie_w)
);

// File: tb/test_gpio_ctrl.sv
`timescale 1ns/1ps
module test_gpio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  pad = '0;
  logic [7:0]  pad_out, pad_oe;
  logic        irq;
  int          total = 0;
  int          bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_ctrl i_gpio_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .we_i (we), .wdata_i (wdata),
    .rdata_o (rdata), .pad_i (pad), .pad_o (pad_out), .pad_oe_o (pad_oe), .irq_o (irq)
  );

  // behavioural reference model
  bit [7:0] m_data, m_dir, m_sense, m_both, m_ev, m_ie, m_edge;
  bit [7:0] padq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = 0; m_dir = 0; m_sense = 0; m_both = 0; m_ev = 0; m_ie = 0; m_edge = 0;
      padq = '{8'h00, 8'h00, 8'h00};
    end else begin
      bit [7:0] cur, old, hit, clr;
      int a;
      cur = padq[1]; old = padq[2]; hit = 0; clr = 0;
      for (int n = 0; n < 8; n++) begin
        bit r, f;
        r = cur[n] && !old[n];
        f = !cur[n] && old[n];
        if (!m_sense[n]) hit[n] = m_both[n] ? (r || f) : (m_ev[n] ? r : f);
      end
      if (we) begin
        a = int'(addr) & 'h7FC;
        if (a < 'h400) begin
          for (int n = 0; n < 8; n++) if ((a >> (n + 2)) & 1) m_data[n] = wdata[n];
        end else begin
          case (a)
            'h400: m_dir = wdata;
            'h404: m_sense = wdata;
            'h408: m_both = wdata;
            'h40C: m_ev = wdata;
            'h410: m_ie = wdata;
            'h41C: clr = wdata;
            default: ;
          endcase
        end
      end
      m_edge = (m_edge & ~clr) | hit;
      padq.push_front(pad);
      void'(padq.pop_back());
    end
  end

  function automatic bit [7:0] m_raw();
    bit [7:0] s, r;
    s = padq[1];
    for (int n = 0; n < 8; n++) r[n] = m_sense[n] ? (m_ev[n] ? s[n] : !s[n]) : m_edge[n];
    return r;
  endfunction

  function automatic bit [7:0] m_read(input logic [10:0] ad);
    int a;
    a = int'(ad) & 'h7FC;
    if (a < 'h400) return ((m_dir & m_data) | (~m_dir & padq[1])) & 8'(a >> 2);
    case (a)
      'h400: return m_dir;
      'h404: return m_sense;
      'h408: return m_both;
      'h40C: return m_ev;
      'h410: return m_ie;
      'h414: return m_raw();
      'h418: return m_raw() & m_ie;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [10:0] ad);
    int a;
    a = int'(ad) & 'h7FC;
    if (a < 'h400) return "R4";
    case (a)
      'h400: return "R3";
      'h404, 'h408, 'h40C: return "R5";
      'h410, 'h418: return "R8";
      'h414: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic cmp(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the clock edge
  always begin
    @(negedge clk);
    #3;
    if (rst_n) begin
      cmp(rdata, m_read(addr), tag_of(addr));
      cmp({7'd0, irq}, {7'd0, |(m_raw() & m_ie)}, "R8");
      cmp(pad_out, m_data, "R2");
      cmp(pad_oe, m_dir, "R3");
    end
  end

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #2;
    cmp(rdata, exp, tag);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 50000);
    total++; bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(11'h400, 8'h00, "R1");
    rd(11'h3FC, 8'h00, "R1");
    rd(11'h414, 8'h00, "R1");
    cmp(pad_oe, 8'h00, "R1");
    cmp({7'd0, irq}, 8'h00, "R1");
    // R3 direction
    wr(11'h400, 8'h0F);
    cmp(pad_oe, 8'h0F, "R3");
    // R2 masked data writes
    wr(11'h020, 8'hFF);
    cmp(pad_out, 8'h08, "R2");
    wr(11'h3FC, 8'hA5);
    cmp(pad_out, 8'hA5, "R2");
    wr(11'h004, 8'h00);
    cmp(pad_out, 8'hA4, "R2");
    // R4 masked reads, mixed directions
    pad = 8'h30;
    settle();
    rd(11'h3FC, 8'h34, "R4");
    rd(11'h010, 8'h04, "R4");
    rd(11'h040, 8'h10, "R4");
    rd(11'h008, 8'h00, "R4");
    // R5 level mode on line 4
    wr(11'h404, 8'h10);
    wr(11'h40C, 8'h10);
    wr(11'h410, 8'h10);
    rd(11'h414, 8'h10, "R5");
    cmp({7'd0, irq}, 8'h01, "R8");
    rd(11'h418, 8'h10, "R8");
    wr(11'h41C, 8'h10);
    rd(11'h414, 8'h10, "R9");
    pad = 8'h20;
    settle();
    rd(11'h414, 8'h00, "R5");
    cmp({7'd0, irq}, 8'h00, "R8");
    wr(11'h40C, 8'h00);
    rd(11'h414, 8'h10, "R5");
    wr(11'h410, 8'h00);
    cmp({7'd0, irq}, 8'h00, "R8");
    wr(11'h404, 8'h00);
    // R6 single edge on line 5
    wr(11'h40C, 8'h20);
    pad = 8'h00;
    settle();
    rd(11'h414, 8'h00, "R6");
    pad = 8'h20;
    settle();
    rd(11'h414, 8'h20, "R6");
    wr(11'h410, 8'h20);
    cmp({7'd0, irq}, 8'h01, "R8");
    rd(11'h418, 8'h20, "R8");
    wr(11'h41C, 8'hDF);
    rd(11'h414, 8'h20, "R9");
    wr(11'h41C, 8'h20);
    rd(11'h414, 8'h00, "R9");
    cmp({7'd0, irq}, 8'h00, "R8");
    wr(11'h40C, 8'h00);
    pad = 8'h00;
    settle();
    rd(11'h414, 8'h20, "R6");
    wr(11'h41C, 8'h20);
    // R7 both edges on line 6
    wr(11'h408, 8'h40);
    pad = 8'h40;
    settle();
    rd(11'h414, 8'h40, "R7");
    wr(11'h41C, 8'h40);
    rd(11'h414, 8'h00, "R9");
    wr(11'h40C, 8'h40);
    pad = 8'h00;
    settle();
    rd(11'h414, 8'h40, "R7");
    wr(11'h41C, 8'h40);
    // R10 event and clear on the same edge, line 7 rising
    wr(11'h40C, 8'h80);
    pad = 8'h80;
    @(negedge clk);
    @(negedge clk);
    wr(11'h41C, 8'h80);
    rd(11'h414, 8'h80, "R10");
    wr(11'h41C, 8'h80);
    rd(11'h414, 8'h00, "R9");
    // R11 read-only and unmapped
    wr(11'h414, 8'hFF);
    rd(11'h414, 8'h00, "R11");
    wr(11'h418, 8'hFF);
    rd(11'h418, 8'h00, "R11");
    rd(11'h41C, 8'h00, "R11");
    rd(11'h420, 8'h00, "R11");
    wr(11'h420, 8'hFF);
    rd(11'h400, 8'h0F, "R11");
    cmp(pad_out, 8'hA4, "R11");
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule